// File: doc/BRIEF.md
# Segment Descriptor Loader and Address Translator

This block keeps six segment registers for a 32-bit core. Each register holds a cached copy of a segment descriptor. The descriptors themselves live in a single global table in ordinary memory, and a 48-bit table register gives that table's base address and byte limit. Writing a 16-bit selector into one of the segment registers starts a two-word read of the matching 8-byte descriptor through a simple 32-bit memory read port. The block then rebuilds the segment base, the limit and the type from the scattered descriptor bytes and stores them in the cache of that register.

Each access arrives as an offset with an access kind, and optionally with an explicit segment. The block picks the segment (by default from the access kind), adds the cached base to the offset to form the linear address, and reports a limit fault or a type fault. Paging is absent, so the linear address is the physical address. Selector loads that point outside the table, use the local-table bit, or put the null entry into the code or stack register are refused and raise a one-cycle fault pulse.

Top module: `seg_unit`

## Requirements
- R1: A selector carries its descriptor index in bits 15:3 and a table indicator in bit 2, and bits 1:0 are ignored. The descriptor is read as two 32-bit words, from table base + index*8 first and then from table base + index*8 + 4.
- R2: When `tbl_ld` is high at a clock edge, the table base and the table limit are loaded from `tbl_base` and `tbl_limit`. Both reset to 0.
- R3: Word 0 bits 15:0 give limit[15:0] and word 0 bits 31:16 give base[15:0]. Word 1 bits 7:0 give base[23:16], word 1 bits 11:8 give the type, and word 1 bits 31:24 give base[31:24]. Word 1 bits 23:12 are ignored.
- R4: `lin_addr` equals the cached base of the selected segment plus `acc_off`, modulo 2^32.
- R5: `lim_fault` is high when `acc_off` is greater than the cached limit. An offset equal to the limit is legal.
- R6: A fetch raises `type_fault` when type bit 3 is clear. A write raises `type_fault` when type bit 3 is set. Stack and read accesses never raise `type_fault`. In this encoding, type 0xA is a code segment and type 0x2 is a data segment.
- R7: Segment codes are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. Access kinds are fetch=0, stack=1, read=2, write=3. When `acc_ovr` is low, a fetch uses CS, a stack access uses SS, and a read or write uses DS. When `acc_ovr` is high, `acc_seg` chooses the segment.
- R8: A selector write is refused when any of these holds: index*8+7 exceeds the table limit, the table indicator is set, or index 0 goes to CS or SS. A refused write leaves the segment unchanged, starts no memory read, and holds `load_fault` high for exactly the one cycle after the write.
- R9: From the clock edge that accepts a selector write until its second word returns, `load_busy` is high. During that time, accesses to the target segment see `acc_ready` low, while accesses to any other segment see `acc_ready` high.
- R10: A selector write that arrives while `load_busy` is high is ignored.
- R11: After reset, every segment has base 0, limit 0 and type 0, and `load_busy`, `mem_req` and `load_fault` are low.
- R12: `mem_req` stays high with a stable, word-aligned `mem_addr` until `mem_rvalid` returns the word. A response takes any number of cycles, including none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_ld | input | 1 | Load the table register |
| tbl_base | input | 32 | New table base |
| tbl_limit | input | 16 | New table byte limit |
| sel_wr | input | 1 | Write a selector into a segment register |
| sel_seg | input | 3 | Target segment code |
| sel_val | input | 16 | Selector value |
| load_busy | output | 1 | A descriptor read is in progress |
| load_fault | output | 1 | Pulse: the last selector write was refused |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read word address |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 32 | Read data |
| acc_valid | input | 1 | Access present |
| acc_kind | input | 2 | Access kind |
| acc_ovr | input | 1 | Use acc_seg instead of the default segment |
| acc_seg | input | 3 | Explicit segment code |
| acc_off | input | 32 | Offset within the segment |
| acc_ready | output | 1 | Selected segment is not loading |
| lin_addr | output | 32 | Linear address |
| lim_fault | output | 1 | Offset beyond the segment limit |
| type_fault | output | 1 | Access kind not allowed by the segment type |

## Verification
The bench sweeps every descriptor index from the null entry to past the table's end into all six segment registers. It uses a range of memory latencies, including zero. After each load it probes the offset at the limit and one above, a wrapping offset, and all three type cases. A design that swapped or shifted the base pieces would return wrong linear addresses. An off-by-one limit compare would fault at the limit or miss the fault one beyond it. A wrong table-end compare would accept the first entry past the table or refuse the last one inside it. The bench also checks default segment choice per access kind, stalls only on the segment being loaded, a selector write dropped during a fetch, and a table that has been moved to a new base.

// File: rtl/seg_pkg.sv
// Shared types and constants for the segment unit.
// Assumes a 32-bit linear space and 8-byte descriptors read as two words.
package seg_pkg;
    localparam int ADDR_W    = 32;
    localparam int SEL_W     = 16;
    localparam int LIM_W     = 16;
    localparam int TYP_W     = 4;
    localparam int SEGID_W   = 3;
    localparam int DESC_SHIFT = 3;

    typedef enum logic [SEGID_W-1:0] {
        SEG_ES = 3'd0, SEG_CS = 3'd1, SEG_SS = 3'd2,
        SEG_DS = 3'd3, SEG_FS = 3'd4, SEG_GS = 3'd5
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0, ACC_STACK = 2'd1, ACC_READ = 2'd2, ACC_WRITE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic [TYP_W-1:0]  typ;
    } seg_desc_t;
endpackage

// File: rtl/seg_sel_check.sv
// Decides whether a selector write is legal against the current table limit.
// Assumes only the global table exists; local-table selectors are refused.
module seg_sel_check
    import seg_pkg::*;
(
    input  logic [SEL_W-1:0]   sel,
    input  logic [SEGID_W-1:0] seg,
    input  logic [LIM_W-1:0]   tbl_limit,
    output logic               fault
);
    localparam int IDX_W = SEL_W - DESC_SHIFT;

    logic [IDX_W-1:0] idx;
    logic [LIM_W-1:0] last_byte;
    logic             null_bad;

    // Combine the three refusal conditions.
    always_comb begin
        idx       = sel[SEL_W-1:DESC_SHIFT];
        last_byte = {idx, {DESC_SHIFT{1'b1}}};
        null_bad  = (idx == '0) && (seg == SEG_CS || seg == SEG_SS);
        fault     = sel[2] | (last_byte > tbl_limit) | null_bad;
    end
endmodule

// File: rtl/seg_fetch.sv
// Two-word descriptor reader. Holds the request and address until the
// word returns, then assembles base, limit and type from the scattered bytes.
// Assumes one fetch at a time; start is only raised while idle.
module seg_fetch
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output seg_desc_t         desc
);
    typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fstate_e;

    fstate_e     state_q;
    logic [31:0] lo_q;

    // Sequence the low and high descriptor words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= F_IDLE;
            mem_addr <= '0;
            lo_q     <= '0;
        end else begin
            case (state_q)
                F_IDLE: if (start) begin
                    state_q  <= F_LO;
                    mem_addr <= start_addr;
                end
                F_LO: if (mem_rvalid) begin
                    state_q  <= F_HI;
                    lo_q     <= mem_rdata;
                    mem_addr <= mem_addr + 32'd4;
                end
                F_HI: if (mem_rvalid) state_q <= F_IDLE;
                default: state_q <= F_IDLE;
            endcase
        end
    end

    // Request and completion strobes plus descriptor assembly.
    always_comb begin
        mem_req    = (state_q != F_IDLE);
        done       = (state_q == F_HI) && mem_rvalid;
        desc.base  = {mem_rdata[31:24], mem_rdata[7:0], lo_q[31:16]};
        desc.limit = lo_q[15:0];
        desc.typ   = mem_rdata[11:8];
    end

    // R12
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
    // R1
    second_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F_LO && mem_rvalid) |=> (mem_addr == $past(mem_addr) + 32'd4));
    // R12
    aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

// File: rtl/seg_xlate_path.sv
// Forms the linear address and the limit and type faults for one access.
// Assumes byte granularity; type bit 3 marks an executable segment.
module seg_xlate_path
    import seg_pkg::*;
(
    input  seg_desc_t         desc,
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] off,
    output logic [ADDR_W-1:0] lin,
    output logic              lim_bad,
    output logic              typ_bad
);
    // Add base, compare limit, screen type against access kind.
    always_comb begin
        lin     = desc.base + off;
        lim_bad = off > {{(ADDR_W-LIM_W){1'b0}}, desc.limit};
        case (kind)
            ACC_FETCH: typ_bad = !desc.typ[3];
            ACC_WRITE: typ_bad = desc.typ[3];
            default:   typ_bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/seg_unit.sv
// Segment register file with descriptor caches and the table register.
// Accepts one selector load at a time, stalls accesses to the segment being
// loaded, and translates offsets through the default or explicit segment.
module seg_unit
    import seg_pkg::*;
#(
    parameter int NUM_SEG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_ld,
    input  logic [31:0]       tbl_base,
    input  logic [15:0]       tbl_limit,
    input  logic              sel_wr,
    input  logic [2:0]        sel_seg,
    input  logic [15:0]       sel_val,
    output logic              load_busy,
    output logic              load_fault,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic              acc_ovr,
    input  logic [2:0]        acc_seg,
    input  logic [31:0]       acc_off,
    output logic              acc_ready,
    output logic [31:0]       lin_addr,
    output logic              lim_fault,
    output logic              type_fault
);
    seg_desc_t              cache_q [NUM_SEG];
    logic [NUM_SEG-1:0]     busy_q;
    logic [SEGID_W-1:0]     tgt_q;
    logic [ADDR_W-1:0]      tb_base_q;
    logic [LIM_W-1:0]       tb_lim_q;
    logic                   fault_q;
    logic                   sel_bad, accept, start, done;
    logic [ADDR_W-1:0]      start_addr;
    seg_desc_t              new_desc, pick_desc;
    logic [SEGID_W-1:0]     pick;
    logic                   lim_bad, typ_bad;

    seg_sel_check u_chk (
        .sel(sel_val), .seg(sel_seg), .tbl_limit(tb_lim_q), .fault(sel_bad)
    );

    // Gate new loads on an idle loader and a legal selector.
    always_comb begin
        accept     = sel_wr && (busy_q == '0);
        start      = accept && !sel_bad;
        start_addr = tb_base_q + {{(ADDR_W-SEL_W){1'b0}},
                                  sel_val[SEL_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
    end

    seg_fetch u_fetch (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .desc(new_desc)
    );

    // Table register and refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_base_q <= '0;
            tb_lim_q  <= '0;
            fault_q   <= 1'b0;
        end else begin
            if (tbl_ld) begin
                tb_base_q <= tbl_base;
                tb_lim_q  <= tbl_limit;
            end
            fault_q <= accept && sel_bad;
        end
    end

    // Per-segment busy flag and descriptor cache.
    generate
        for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    busy_q[g]  <= 1'b0;
                    cache_q[g] <= '0;
                end else if (start && sel_seg == SEGID_W'(g)) begin
                    busy_q[g]  <= 1'b1;
                end else if (done && busy_q[g]) begin
                    busy_q[g]  <= 1'b0;
                    cache_q[g] <= new_desc;
                end
            end
        end
    endgenerate

    // Remember the load target for assertion-side bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n)     tgt_q <= '0;
        else if (start) tgt_q <= sel_seg;
    end

    // Choose the segment from the access kind unless overridden.
    always_comb begin
        if (acc_ovr) pick = acc_seg;
        else begin
            case (acc_kind)
                ACC_FETCH: pick = SEG_CS;
                ACC_STACK: pick = SEG_SS;
                default:   pick = SEG_DS;
            endcase
        end
        pick_desc = cache_q[pick];
    end

    seg_xlate_path u_xl (
        .desc(pick_desc), .kind(acc_kind), .off(acc_off),
        .lin(lin_addr), .lim_bad(lim_bad), .typ_bad(typ_bad)
    );

    // Drive the access-side outputs.
    always_comb begin
        load_busy  = |busy_q;
        load_fault = fault_q;
        acc_ready  = !busy_q[pick];
        lim_fault  = acc_valid && acc_ready && lim_bad;
        type_fault = acc_valid && acc_ready && typ_bad;
    end

    // R9
    one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_q));
    // R8
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_fault |-> $past(sel_wr));
    // R8
    no_fetch_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_fault) |-> !$rose(mem_req));
    // R9
    busy_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_busy |-> busy_q[tgt_q]);
endmodule

// File: tb/test_seg_unit.sv
module test_seg_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_ld = 0;
    logic [31:0] tbl_base = 0;
    logic [15:0] tbl_limit = 0;
    logic        sel_wr = 0;
    logic [2:0]  sel_seg = 0;
    logic [15:0] sel_val = 0;
    logic        load_busy, load_fault, mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 0;
    logic [31:0] mem_rdata = 0;
    logic        acc_valid = 0;
    logic [1:0]  acc_kind = 0;
    logic        acc_ovr = 0;
    logic [2:0]  acc_seg = 0;
    logic [31:0] acc_off = 0;
    logic        acc_ready, lim_fault, type_fault;
    logic [31:0] lin_addr;

    int total = 0, bad = 0;
    int mem_lat = 0, mem_cnt = 0;
    logic [31:0] tb_tbase = 0;
    logic [15:0] tb_tlim = 0;
    logic [31:0] eb [6];
    logic [15:0] el [6];
    logic [3:0]  et [6];

    seg_unit i_seg_unit (.*);

    always #2 clk = ~clk;

    function automatic logic [31:0] dbase(int i);
        return 32'h9E37_79B9 * (i + 1);
    endfunction
    function automatic logic [15:0] dlim(int i);
        return 16'h00FF + 16'h0101 * i[15:0];
    endfunction
    function automatic logic [3:0] dtyp(int i);
        return i[0] ? 4'hA : 4'h2;
    endfunction

    // memory model: answers after mem_lat idle cycles
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid <= 0;
            mem_cnt    <= 0;
        end else if (mem_req) begin
            if (mem_cnt >= mem_lat) begin
                int idx;
                logic [31:0] b;
                idx = int'((mem_addr - tb_tbase) >> 3);
                b   = dbase(idx);
                mem_rvalid <= 1;
                if (mem_addr[2]) mem_rdata <= {b[31:24], 8'h5C, 4'h9, dtyp(idx), b[23:16]};
                else             mem_rdata <= {b[15:0], dlim(idx)};
            end else mem_cnt <= mem_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 60 && load_busy; n++) @(negedge clk);
    endtask

    task automatic do_load(input int seg, input logic [15:0] sv, input int lat);
        int idx;
        bit ef;
        idx = int'(sv[15:3]);
        ef = sv[2] || ({sv[15:3], 3'b111} > tb_tlim) || (idx == 0 && (seg == 1 || seg == 2));
        mem_lat = lat;
        @(negedge clk);
        sel_wr = 1; sel_seg = seg[2:0]; sel_val = sv;
        @(negedge clk);
        sel_wr = 0;
        chk(load_fault == ef, "R8 load_fault", {31'b0, load_fault}, {31'b0, ef});
        wait_idle();
        if (!ef) begin
            eb[seg] = dbase(idx); el[seg] = dlim(idx); et[seg] = dtyp(idx);
        end
    endtask

    task automatic probe(input bit ovr, input int seg, input logic [1:0] kind, input logic [31:0] off);
        @(negedge clk);
        acc_valid = 1; acc_ovr = ovr; acc_seg = seg[2:0]; acc_kind = kind; acc_off = off;
        #1;
    endtask

    task automatic full_probe(input int s);
        probe(1, s, 2'd2, 0);
        chk(lin_addr == eb[s] && acc_ready, "R3 base", lin_addr, eb[s]);
        probe(1, s, 2'd2, 32'hFFFF_FFF0);
        chk(lin_addr == eb[s] + 32'hFFFF_FFF0, "R4 wrap", lin_addr, eb[s] + 32'hFFFF_FFF0);
        probe(1, s, 2'd2, {16'b0, el[s]});
        chk(!lim_fault, "R5 at limit", {31'b0, lim_fault}, 0);
        probe(1, s, 2'd1, {16'b0, el[s]} + 1);
        chk(lim_fault, "R5 over limit", {31'b0, lim_fault}, 1);
        probe(1, s, 2'd0, 0);
        chk(type_fault == !et[s][3], "R6 fetch", {31'b0, type_fault}, {31'b0, !et[s][3]});
        probe(1, s, 2'd3, 0);
        chk(type_fault == et[s][3], "R6 write", {31'b0, type_fault}, {31'b0, et[s][3]});
        probe(1, s, 2'd2, 0);
        chk(!type_fault, "R6 read", {31'b0, type_fault}, 0);
    endtask

    task automatic set_table(input logic [31:0] b, input logic [15:0] l);
        @(negedge clk);
        tbl_ld = 1; tbl_base = b; tbl_limit = l;
        @(negedge clk);
        tbl_ld = 0; tb_tbase = b; tb_tlim = l;
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < 6; s++) begin eb[s] = 0; el[s] = 0; et[s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(!load_busy && !mem_req && !load_fault, "R11 idle", {29'b0, load_busy, mem_req, load_fault}, 0);
        for (int s = 0; s < 6; s++) begin
            probe(1, s, 2'd2, 32'h1234);
            chk(lin_addr == 32'h1234, "R11 base zero", lin_addr, 32'h1234);
            probe(1, s, 2'd2, 1);
            chk(lim_fault, "R11 limit zero", {31'b0, lim_fault}, 1);
            probe(1, s, 2'd0, 0);
            chk(type_fault, "R11 type zero", {31'b0, type_fault}, 1);
        end
        // R2 reset table limit 0 refuses index 1
        do_load(3, 16'h0008, 0);
        set_table(32'h0001_0000, 16'd127);
        // R1 R3 sweep: every index, every segment, varying latency
        for (int idx = 0; idx < 18; idx++)
            for (int s = 0; s < 6; s++) begin
                do_load(s, {idx[12:0], 1'b0, idx[1:0]}, (idx + s) % 4);
                full_probe(s);
            end
        // R8 table indicator refused, register unchanged
        do_load(4, {13'd5, 1'b1, 2'b00}, 0);
        full_probe(4);
        // R7 default segment choice
        do_load(1, {13'd3, 3'b0}, 1);
        do_load(2, {13'd4, 3'b0}, 2);
        do_load(3, {13'd6, 3'b0}, 0);
        do_load(0, {13'd7, 3'b0}, 0);
        do_load(4, {13'd8, 3'b0}, 0);
        do_load(5, {13'd9, 3'b0}, 0);
        probe(0, 0, 2'd0, 5);
        chk(lin_addr == eb[1] + 5, "R7 fetch uses CS", lin_addr, eb[1] + 5);
        probe(0, 0, 2'd1, 5);
        chk(lin_addr == eb[2] + 5, "R7 stack uses SS", lin_addr, eb[2] + 5);
        probe(0, 0, 2'd2, 5);
        chk(lin_addr == eb[3] + 5, "R7 read uses DS", lin_addr, eb[3] + 5);
        probe(0, 5, 2'd3, 5);
        chk(lin_addr == eb[3] + 5, "R7 write uses DS", lin_addr, eb[3] + 5);
        for (int s = 0; s < 6; s++) begin
            probe(1, s, 2'd2, 5);
            chk(lin_addr == eb[s] + 5, "R7 override", lin_addr, eb[s] + 5);
        end
        // R9 stall and R10 ignored write
        mem_lat = 6;
        @(negedge clk);
        sel_wr = 1; sel_seg = 3; sel_val = {13'd10, 3'b0};
        @(negedge clk);
        sel_wr = 0;
        chk(load_busy, "R9 busy", {31'b0, load_busy}, 1);
        probe(1, 3, 2'd2, 0);
        chk(!acc_ready, "R9 target stalls", {31'b0, acc_ready}, 0);
        probe(1, 1, 2'd2, 0);
        chk(acc_ready, "R9 other ready", {31'b0, acc_ready}, 1);
        @(negedge clk);
        sel_wr = 1; sel_seg = 0; sel_val = {13'd11, 3'b0};
        @(negedge clk);
        sel_wr = 0;
        chk(!load_fault, "R10 no pulse", {31'b0, load_fault}, 0);
        wait_idle();
        eb[3] = dbase(10); el[3] = dlim(10); et[3] = dtyp(10);
        full_probe(3);
        full_probe(0);
        chk(!mem_req, "R10 no second fetch", {31'b0, mem_req}, 0);
        // R2 moved table
        set_table(32'h0002_0000, 16'd31);
        do_load(4, {13'd2, 3'b0}, 3);
        full_probe(4);
        do_load(4, {13'd4, 3'b0}, 0);
        full_probe(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule